// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple register bus and the pins of a NAND flash device. Software programs three strobe phase lengths and a control word. After that, each write to the command or address register becomes one latch cycle on the flash bus. Each access to the data register becomes one or four byte transfers. A 32-bit data access is split into four byte cycles, lowest byte first. A byte access moves a single byte.

Every byte cycle has three phases:
- a setup phase, in which the latch lines and the data are driven while the strobe stays high;
- an active phase, in which the write or read strobe is low;
- a hold phase.

Each phase length is stored as count minus one. The register bus stalls the requester through `bus_ready` until a flash cycle has finished. Software owns the chip-enable line outright. The flash ready/busy pin is synchronised and shown as a status bit. A control bit requests a one-cycle clear pulse for an external ECC accumulator.

Top module: `nand_bus_seq`

## Requirements
- R1: Registers sit at word offsets 0x00 (timing), 0x04 (control), 0x08 (command), 0x0C (address), 0x10 (data) and 0x20 (status). After reset:
  - the timing register reads 0x3770 (default narrow setup field);
  - the control register reads 0x2;
  - `nf_ce_n` is 1, `nf_we_n` and `nf_re_n` are 1, and `nf_cle` and `nf_ale` are 0.
- R2: The timing register fields are:
  - setup count minus one at bits 13:12 (bits 14:12 when `WIDE_SETUP`=1);
  - active count minus one at bits 10:8;
  - hold count minus one at bits 6:4.
  All other bits read 0.
- R3: For field values s, a and h, each byte cycle has s+1 setup cycles with the strobe high, then a+1 cycles with the strobe low, then h+1 hold cycles. An access of N byte cycles completes on the N*(s+a+h+3)+2-th clock edge after it is presented.
- R4: A command write drives its low byte on `nf_dq_out` with `nf_cle`=1 and `nf_ale`=0 for the whole cycle. An address write does the same with `nf_ale`=1 and `nf_cle`=0. A data cycle asserts neither latch line.
- R5: A data write with `bus_word`=1 produces four `nf_we_n` strobes, carrying bits 7:0, 15:8, 23:16 and 31:24 in that order. With `bus_word`=0 it produces one strobe carrying bits 7:0.
- R6: A data read pulses `nf_re_n` and samples `nf_dq_in` in the last cycle of each active phase. A word read returns the first byte in bits 7:0 and the fourth in bits 31:24. A byte read returns the byte zero-extended.
- R7: While control bit 0 (enable) is 0, command, address and data accesses cause no strobe and complete on the first edge, and data reads return 0.
- R8: `nf_ce_n` equals control bit 1 (1 = flash deselected).
- R9: Writing 1 to control bit 4 gives exactly one cycle of `ecc_clear`. Bit 4 always reads 0.
- R10: Status bit 0 shows the `nf_rb` pin (1 = ready, 0 = busy) through a two-flop synchroniser.
- R11: While a flash cycle runs, `bus_ready` stays low. `nf_we_n` and `nf_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit data access, 0 = byte |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes at the next edge |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Output enable for `nf_dq_out` |
| nf_dq_in | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready/busy pin, 1 = ready |
| ecc_clear | output | 1 | One-cycle ECC accumulator clear |

## Verification
The assertions assume a single requester that holds `bus_sel` and its fields steady until `bus_ready` is seen. They also assume that timing and control are rewritten only between accesses, never during a flash cycle. The bench drives every request half a cycle away from the active edge and keeps it unchanged until completion. It models the flash read data as a byte that advances on each read strobe, so sampling in the last active cycle is the only way to return the expected word.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter bit WIDE_SETUP = 1'b0,
  parameter int PHASE_W    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_word,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_ready,
  output logic [31:0] bus_rdata,
  output logic        nf_ce_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_out,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_in,
  input  logic        nf_rb,
  output logic        ecc_clear
);
  localparam int SETUP_W = WIDE_SETUP ? 3 : 2;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACT, S_HOLD, S_DONE} phase_t;

  phase_t               state;
  logic [SETUP_W-1:0]   setup_q;
  logic [PHASE_W-1:0]   act_q, hold_q, cnt;
  logic                 en_q, ce_q, ecc_q, rb_s1, rb_s2;
  logic [1:0]           byte_idx, last_idx;
  logic                 op_rd, op_cle, op_ale;
  logic [31:0]          wbuf, rbuf;

  logic [3:0] widx;
  logic is_cfg, is_ctl, is_cmd, is_adr, is_dat, is_sts;
  logic starts, launch, reg_wr, in_cycle;
  logic [31:0] reg_rd;

  assign widx   = bus_addr[5:2];
  assign is_cfg = widx == 4'd0;
  assign is_ctl = widx == 4'd1;
  assign is_cmd = widx == 4'd2;
  assign is_adr = widx == 4'd3;
  assign is_dat = widx == 4'd4;
  assign is_sts = widx == 4'd8;

  assign starts   = bus_sel && en_q && ((bus_wr && (is_cmd || is_adr)) || is_dat);
  assign launch   = (state == S_IDLE) && starts;
  assign reg_wr   = (state == S_IDLE) && bus_sel && bus_wr && !starts;
  assign in_cycle = (state == S_SETUP) || (state == S_ACT) || (state == S_HOLD);

  always_comb begin
    reg_rd = 32'd0;
    if (is_cfg)      reg_rd = (32'(setup_q) << 12) | (32'(act_q) << 8) | (32'(hold_q) << 4);
    else if (is_ctl) reg_rd = {30'd0, ce_q, en_q};
    else if (is_sts) reg_rd = {31'd0, rb_s2};
  end

  assign bus_ready = ((state == S_IDLE) && !starts) || (state == S_DONE);
  assign bus_rdata = (state == S_DONE) ? rbuf : reg_rd;

  assign nf_ce_n   = ce_q;
  assign nf_cle    = in_cycle && op_cle;
  assign nf_ale    = in_cycle && op_ale;
  assign nf_we_n   = !((state == S_ACT) && !op_rd);
  assign nf_re_n   = !((state == S_ACT) && op_rd);
  assign nf_dq_oe  = in_cycle && !op_rd;
  assign nf_dq_out = wbuf[{byte_idx, 3'b000} +: 8];
  assign ecc_clear = ecc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= '1;
      act_q   <= '1;
      hold_q  <= '1;
      en_q    <= 1'b0;
      ce_q    <= 1'b1;
      ecc_q   <= 1'b0;
    end else begin
      ecc_q <= 1'b0;
      if (reg_wr && is_cfg) begin
        setup_q <= bus_wdata[12 +: SETUP_W];
        act_q   <= bus_wdata[8 +: PHASE_W];
        hold_q  <= bus_wdata[4 +: PHASE_W];
      end
      if (reg_wr && is_ctl) begin
        en_q  <= bus_wdata[0];
        ce_q  <= bus_wdata[1];
        ecc_q <= bus_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1 <= 1'b0;
      rb_s2 <= 1'b0;
    end else begin
      rb_s1 <= nf_rb;
      rb_s2 <= rb_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      byte_idx <= '0;
      last_idx <= '0;
      op_rd    <= 1'b0;
      op_cle   <= 1'b0;
      op_ale   <= 1'b0;
      wbuf     <= '0;
      rbuf     <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state    <= S_SETUP;
          cnt      <= PHASE_W'(setup_q);
          byte_idx <= 2'd0;
          last_idx <= (is_dat && bus_word) ? 2'd3 : 2'd0;
          op_rd    <= !bus_wr;
          op_cle   <= is_cmd;
          op_ale   <= is_adr;
          wbuf     <= bus_wdata;
          rbuf     <= '0;
        end
        S_SETUP: if (cnt == '0) begin
          state <= S_ACT;
          cnt   <= act_q;
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          state <= S_HOLD;
          cnt   <= hold_q;
          if (op_rd) rbuf[{byte_idx, 3'b000} +: 8] <= nf_dq_in;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt == '0) begin
          if (byte_idx == last_idx) state <= S_DONE;
          else begin
            state    <= S_SETUP;
            cnt      <= PHASE_W'(setup_q);
            byte_idx <= byte_idx + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  a_r5_dq_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_dq_out));

  a_r9_ecc_single: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_clear |=> !ecc_clear);

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (nf_we_n && nf_re_n));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !bus_ready);
endmodule

// File: tb/nand_bus_seq_bench.sv
module nand_bus_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, ecc_clear;
  logic [7:0]  nf_dq_out, nf_dq_in;
  logic        nf_rb = 1'b1;
  logic [7:0]  rd_base = 8'h00;

  int checks = 0, errors = 0, wd = 0;
  int mon_low, mon_strb, mon_pre, mon_ecc;
  logic mon_seen, mon_prev, mon_cle, mon_ale;
  logic [7:0] mon_last;
  logic [7:0] mon_byte [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign nf_dq_in = rd_base + 8'(mon_strb);

  nand_bus_seq u_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb),
    .ecc_clear(ecc_clear)
  );

  always @(negedge clk) begin
    if (!nf_we_n || !nf_re_n) begin
      mon_low++;
      mon_seen = 1'b1;
      mon_last = nf_dq_out;
    end else if (!mon_seen && nf_dq_oe) mon_pre++;
    if (nf_cle) mon_cle = 1'b1;
    if (nf_ale) mon_ale = 1'b1;
    if (mon_prev && nf_we_n && nf_re_n) begin
      if (mon_strb < 4) mon_byte[mon_strb] = mon_last;
      mon_strb++;
    end
    mon_prev = !nf_we_n || !nf_re_n;
    if (ecc_clear) mon_ecc++;
  end

  task automatic mon_clear();
    mon_low = 0; mon_strb = 0; mon_pre = 0; mon_ecc = 0;
    mon_seen = 1'b0; mon_prev = 1'b0; mon_cle = 1'b0; mon_ale = 1'b0;
    for (int k = 0; k < 4; k++) mon_byte[k] = 8'h00;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic word, input logic [5:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rdata, output int cyc);
    @(negedge clk); #1;
    mon_clear();
    bus_sel = 1'b1; bus_wr = wr; bus_word = word; bus_addr = addr; bus_wdata = wdata;
    cyc = 0;
    #1;
    while (!bus_ready) begin
      @(posedge clk); cyc++;
      @(negedge clk); #1;
    end
    rdata = bus_rdata;
    @(posedge clk); cyc++;
    @(negedge clk); #1;
    bus_sel = 1'b0;
  endtask

  localparam logic [47:0] VEC [8] = '{
    {2'd0, 1'b0, 3'd0, 3'd0, 3'd0, 4'd0, 32'h0000_0070},
    {2'd1, 1'b0, 3'd1, 3'd2, 3'd0, 4'd0, 32'h0000_005A},
    {2'd2, 1'b0, 3'd2, 3'd1, 3'd3, 4'd0, 32'h0000_00C3},
    {2'd2, 1'b1, 3'd0, 3'd0, 3'd1, 4'd0, 32'h1122_3344},
    {2'd3, 1'b0, 3'd1, 3'd1, 3'd1, 4'd0, 32'h0000_0080},
    {2'd3, 1'b1, 3'd3, 3'd7, 3'd7, 4'd0, 32'h0000_00F0},
    {2'd0, 1'b0, 3'd3, 3'd7, 3'd7, 4'd0, 32'h0000_00FF},
    {2'd2, 1'b1, 3'd1, 3'd3, 3'd2, 4'd0, 32'hA55A_0FF0}
  };

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [31:0] rd;
  int cyc, n;
  logic [1:0] kind;
  logic word;
  logic [2:0] s, a, h;
  logic [31:0] d, exp_rd;
  logic [5:0] addr;

  initial begin
    mon_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    chk("R1 reset ce_n", {31'd0, nf_ce_n}, 32'd1);
    chk("R1 reset strobes", {30'd0, nf_we_n, nf_re_n}, 32'd3);
    chk("R1 reset latches", {30'd0, nf_cle, nf_ale}, 32'd0);
    access(1'b0, 1'b0, 6'h00, 32'd0, rd, cyc);
    chk("R1 reset timing reg", rd, 32'h0000_3770);
    access(1'b0, 1'b0, 6'h04, 32'd0, rd, cyc);
    chk("R1 reset control reg", rd, 32'h0000_0002);

    access(1'b1, 1'b0, 6'h08, 32'h90, rd, cyc);
    chk("R7 disabled cmd cycles", cyc, 1);
    chk("R7 disabled cmd strobes", mon_strb, 0);
    access(1'b0, 1'b1, 6'h10, 32'd0, rd, cyc);
    chk("R7 disabled data read value", rd, 32'd0);
    chk("R7 disabled data read strobes", mon_strb, 0);

    access(1'b1, 1'b0, 6'h00, 32'hFFFF_FFFF, rd, cyc);
    access(1'b0, 1'b0, 6'h00, 32'd0, rd, cyc);
    chk("R2 unused timing bits", rd, 32'h0000_3770);

    access(1'b1, 1'b0, 6'h04, 32'h1, rd, cyc);
    chk("R8 ce low after enable", {31'd0, nf_ce_n}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      kind = VEC[i][47:46]; word = VEC[i][45];
      s = VEC[i][44:42]; a = VEC[i][41:39]; h = VEC[i][38:36]; d = VEC[i][31:0];
      n = word ? 4 : 1;
      addr = (kind == 2'd0) ? 6'h08 : (kind == 2'd1) ? 6'h0C : 6'h10;
      access(1'b1, 1'b0, 6'h00, (32'(s) << 12) | (32'(a) << 8) | (32'(h) << 4), rd, cyc);
      access(1'b0, 1'b0, 6'h00, 32'd0, rd, cyc);
      chk("R2 timing readback", rd, (32'(s) << 12) | (32'(a) << 8) | (32'(h) << 4));
      if (kind == 2'd3) rd_base = d[7:0];
      access(kind != 2'd3, word, addr, d, rd, cyc);
      chk("R3 R11 access cycles", cyc, n * (int'(s) + int'(a) + int'(h) + 3) + 2);
      chk("R3 strobe low cycles", mon_low, n * (int'(a) + 1));
      chk("R5 R6 strobe count", mon_strb, n);
      chk("R4 cle seen", {31'd0, mon_cle}, {31'd0, kind == 2'd0});
      chk("R4 ale seen", {31'd0, mon_ale}, {31'd0, kind == 2'd1});
      if (kind != 2'd3) begin
        chk("R3 setup cycles", mon_pre, int'(s) + 1);
        if (word) chk("R5 write bytes lsb first",
                      {mon_byte[3], mon_byte[2], mon_byte[1], mon_byte[0]}, d);
        else      chk("R4 R5 single byte", {24'd0, mon_byte[0]}, {24'd0, d[7:0]});
      end else begin
        exp_rd = word ? {d[7:0] + 8'd3, d[7:0] + 8'd2, d[7:0] + 8'd1, d[7:0]} : {24'd0, d[7:0]};
        chk("R6 read data", rd, exp_rd);
      end
    end

    access(1'b1, 1'b0, 6'h04, 32'h3, rd, cyc);
    chk("R8 ce high", {31'd0, nf_ce_n}, 32'd1);
    access(1'b0, 1'b0, 6'h04, 32'd0, rd, cyc);
    chk("R8 control readback", rd, 32'h3);

    access(1'b1, 1'b0, 6'h04, 32'h11, rd, cyc);
    repeat (3) @(negedge clk);
    chk("R9 ecc clear pulses", mon_ecc, 1);
    access(1'b0, 1'b0, 6'h04, 32'd0, rd, cyc);
    chk("R9 bit4 reads zero", rd, 32'h1);

    @(negedge clk); #1; nf_rb = 1'b0;
    repeat (3) @(posedge clk);
    access(1'b0, 1'b0, 6'h20, 32'd0, rd, cyc);
    chk("R10 status busy", rd, 32'd0);
    @(negedge clk); #1; nf_rb = 1'b1;
    repeat (3) @(posedge clk);
    access(1'b0, 1'b0, 6'h20, 32'd0, rd, cyc);
    chk("R10 status ready", rd, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule